// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block gathers fifteen interrupt sources, IRQ0 to IRQ14, for a small 8-bit processor. Each source has a pending bit and an enable bit, held in two pairs of 8-bit registers: a low pair for IRQ0–IRQ6 and a high pair for IRQ7–IRQ14. A single global enable sits in the top bit of the low enable register. Pending bits are set by one-cycle hardware pulses or by register writes from the processor. A software-set bit is treated exactly like a hardware request.

When the processor reports an instruction boundary, or while it is halted, the block looks for pending requests whose enable bit is set. If the global enable is on, it takes the lowest-numbered such request. In that same cycle it raises an acknowledge, gives the source number and the vector-table address, and clears both the serviced pending bit and the global enable.

Over the next three cycles the block writes the return address and the flags onto a byte-wide stack port, and then hands back the lowered stack pointer. A return request starts the mirror sequence. That sequence reads the flags and the return address back, hands out the restored values and the raised stack pointer, and turns the global enable back on. A source whose enable bit is clear is never taken automatically, so software can poll its pending bit instead.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset all four registers read 0 and no sequence runs. The register port selects with code 0 the low pending register (bits 0–6 are IRQ0–IRQ6, and bit 7 reads 0), with code 1 the high pending register (bits 0–7 are IRQ7–IRQ14), with code 2 the low enable register (bits 0–6 enable IRQ0–IRQ6, and bit 7 is the global enable), and with code 3 the high enable register (bits 0–7 enable IRQ7–IRQ14). A write replaces the whole selected register on the next clock, and reads are combinational.
- R2: A high level on `irq_pulse[n]` at a clock edge sets pending bit n. It wins over a register write of 0 to that bit and over an acknowledge clear of that bit in the same cycle.
- R3: A pending bit set by a register write is taken, with the same priority and vector, just as a hardware-set bit would be.
- R4: `gie_clr` clears only the global enable and `gie_set` sets only it. Neither one changes an individual enable bit. When several sources act in one cycle, the priority from highest to lowest is: an acknowledge (clears), then the end of a return (sets), then `gie_clr`, then `gie_set`, then a register write.
- R5: The block takes a request in a cycle where no sequence runs, `iret_req` is low, the global enable is 1, at least one request is both pending and enabled, and either `cpu_boundary` or `halted` is 1. In that cycle `int_ack` is 1, `irq_id` is the lowest-numbered pending enabled source n, and `vec_addr` is 2·n+2. At that clock edge pending bit n and the global enable are cleared.
- R6: A pending bit whose enable bit is 0 is never acknowledged, and it stays readable on the register port.
- R7: In the three cycles after an acknowledge, `stk_we` is 1. The writes go to SP−1 with the return-address low byte, then to SP−2 with the high byte, then to SP−3 with the flags. SP, `pc_in` and `flags_in` are the values sampled in the acknowledge cycle. In the third cycle `sp_wr` is 1 and `sp_new` is SP−3.
- R8: `iret_req` in a cycle with no sequence running starts three read cycles with `stk_re` at 1. They read SP (the flags), SP+1 (the return-address high byte) and SP+2 (the low byte), using the SP sampled at the start. Reads return data in the same cycle. In the third cycle `restore_valid` is 1 with the restored flags and address, and `sp_wr` is 1 with `sp_new` equal to SP+3. The global enable is 1 from the next cycle.
- R9: `halt_cmd` sets `halted` from the next cycle. An acknowledge clears it at its edge. While halted, a request is taken without `cpu_boundary`.
- R10: No acknowledge is given while a push or pop sequence runs. When `iret_req` and an acknowledge condition meet in an idle cycle, the return wins and no acknowledge is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_pulse | input | 15 | Hardware request pulses, bit n for IRQn |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Register selected for the write |
| reg_wr_data | input | 8 | Write data |
| reg_rd_sel | input | 2 | Register selected for the read |
| reg_rd_data | output | 8 | Read data |
| gie_set | input | 1 | Turn the global enable on |
| gie_clr | input | 1 | Turn the global enable off |
| cpu_boundary | input | 1 | Processor is at an instruction boundary |
| halt_cmd | input | 1 | Processor enters the halted state |
| iret_req | input | 1 | Return from the service routine |
| pc_in | input | 16 | Return address to save |
| flags_in | input | 8 | Flags to save |
| sp_in | input | 8 | Current stack pointer |
| int_ack | output | 1 | Request taken in this cycle |
| irq_id | output | 4 | Number of the source taken |
| vec_addr | output | 16 | Vector-table address of that source |
| halted | output | 1 | Halted state |
| stk_we | output | 1 | Stack byte write |
| stk_re | output | 1 | Stack byte read |
| stk_addr | output | 8 | Stack byte address |
| stk_wdata | output | 8 | Stack write data |
| stk_rdata | input | 8 | Stack read data, same cycle |
| sp_wr | output | 1 | Load new stack pointer |
| sp_new | output | 8 | New stack pointer value |
| restore_valid | output | 1 | Restored flags and address are valid |
| restore_pc | output | 16 | Restored return address |
| restore_flags | output | 8 | Restored flags |

## Verification
A stale pending or enable bit shows up on the register port in the cycle that follows. It also shows up as an acknowledge that is missing, comes early, or names the wrong source, at the next boundary. A wrong global enable shows up one cycle after the event, either as a masked source being taken or as a lost acknowledge. A phase error in the sequencer changes the stack strobes, the address or the write data in the next cycle. A lost byte from the pop is seen in the restore outputs three cycles after the return request.

// File: rtl/vic_pkg.sv
package vic_pkg;

    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_PUSH_LO = 3'd1,
        PH_PUSH_HI = 3'd2,
        PH_PUSH_FL = 3'd3,
        PH_POP_FL  = 3'd4,
        PH_POP_HI  = 3'd5,
        PH_POP_LO  = 3'd6
    } vic_phase_e;

    localparam logic [1:0] SEL_REQ_LO  = 2'd0;
    localparam logic [1:0] SEL_REQ_HI  = 2'd1;
    localparam logic [1:0] SEL_MASK_LO = 2'd2;
    localparam logic [1:0] SEL_MASK_HI = 2'd3;

endpackage

// File: rtl/vic_prio_enc.sv
module vic_prio_enc #(
    parameter  int N    = 15,
    localparam int ID_W = $clog2(N)
) (
    input  logic [N-1:0]    vec,
    output logic            found,
    output logic [N-1:0]    sel,
    output logic [ID_W-1:0] id
);

    // seen[i] is set when any bit below i is set
    logic [N:0] seen;
    assign seen[0] = 1'b0;

    for (genvar gi = 0; gi < N; gi++) begin : g_chain
        assign sel[gi]    = vec[gi] & ~seen[gi];
        assign seen[gi+1] = seen[gi] | vec[gi];
    end

    assign found = seen[N];

    always_comb begin
        id = '0;
        for (int i = 0; i < N; i++) begin
            if (sel[i]) id = id | ID_W'(i);
        end
    end

endmodule

// File: rtl/vic_req_mask.sv
module vic_req_mask
    import vic_pkg::*;
#(
    parameter  int NUM_SRC = 15,
    parameter  int LO_BITS = 7,
    parameter  int DATA_W  = 8,
    localparam int HI_BITS = NUM_SRC - LO_BITS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_pulse,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               gie_set,
    input  logic               gie_clr,
    input  logic               ack,
    input  logic [NUM_SRC-1:0] ack_sel,
    input  logic               restore,
    input  logic [1:0]         rd_sel,
    output logic [DATA_W-1:0]  rd_data,
    output logic [NUM_SRC-1:0] req_o,
    output logic [NUM_SRC-1:0] mask_o,
    output logic               gie_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] req;
        logic [NUM_SRC-1:0] mask;
        logic               gie;
    } rm_state_t;

    rm_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (wr_sel)
                SEL_REQ_LO:  st_d.req[LO_BITS-1:0]        = wr_data[LO_BITS-1:0];
                SEL_REQ_HI:  st_d.req[NUM_SRC-1:LO_BITS]  = wr_data[HI_BITS-1:0];
                SEL_MASK_LO: begin
                    st_d.mask[LO_BITS-1:0] = wr_data[LO_BITS-1:0];
                    st_d.gie               = wr_data[DATA_W-1];
                end
                default:     st_d.mask[NUM_SRC-1:LO_BITS] = wr_data[HI_BITS-1:0];
            endcase
        end
        // later lines win: write < set < clr < restore < ack
        if (gie_set) st_d.gie = 1'b1;
        if (gie_clr) st_d.gie = 1'b0;
        if (restore) st_d.gie = 1'b1;
        if (ack) begin
            st_d.req = st_d.req & ~ack_sel;
            st_d.gie = 1'b0;
        end
        // hardware pulses override any clear in the same cycle
        st_d.req = st_d.req | irq_pulse;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data = '0;
        case (rd_sel)
            SEL_REQ_LO:  rd_data[LO_BITS-1:0] = st_q.req[LO_BITS-1:0];
            SEL_REQ_HI:  rd_data[HI_BITS-1:0] = st_q.req[NUM_SRC-1:LO_BITS];
            SEL_MASK_LO: begin
                rd_data[LO_BITS-1:0] = st_q.mask[LO_BITS-1:0];
                rd_data[DATA_W-1]    = st_q.gie;
            end
            default:     rd_data[HI_BITS-1:0] = st_q.mask[NUM_SRC-1:LO_BITS];
        endcase
    end

    assign req_o  = st_q.req;
    assign mask_o = st_q.mask;
    assign gie_o  = st_q.gie;

    assert_pulse_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pulse != '0) |=> ((st_q.req & $past(irq_pulse)) == $past(irq_pulse)));

    assert_ack_drops_gie_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !st_q.gie);

    assert_disable_keeps_enables_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (gie_clr && !restore && !(wr_en && (wr_sel == SEL_MASK_LO || wr_sel == SEL_MASK_HI)))
        |=> (!st_q.gie && $stable(st_q.mask)));

endmodule

// File: rtl/vic_seq.sv
module vic_seq
    import vic_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int SP_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              iret_req,
    input  logic              halt_cmd,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [DATA_W-1:0] flags_in,
    input  logic [SP_W-1:0]   sp_in,
    input  logic [DATA_W-1:0] stk_rdata,
    output logic              busy,
    output logic              halted,
    output logic              stk_we,
    output logic              stk_re,
    output logic [SP_W-1:0]   stk_addr,
    output logic [DATA_W-1:0] stk_wdata,
    output logic              sp_wr,
    output logic [SP_W-1:0]   sp_new,
    output logic              restore_valid,
    output logic [ADDR_W-1:0] restore_pc,
    output logic [DATA_W-1:0] restore_flags
);

    typedef struct packed {
        vic_phase_e        phase;
        logic [ADDR_W-1:0] pc;
        logic [DATA_W-1:0] flags;
        logic [SP_W-1:0]   sp;
        logic [DATA_W-1:0] pchi;
        logic              halted;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        stk_we        = 1'b0;
        stk_re        = 1'b0;
        stk_addr      = '0;
        stk_wdata     = '0;
        sp_wr         = 1'b0;
        sp_new        = '0;
        restore_valid = 1'b0;
        restore_pc    = '0;
        restore_flags = '0;
        case (st_q.phase)
            PH_IDLE: begin
                if (take) begin
                    st_d.phase = PH_PUSH_LO;
                    st_d.pc    = pc_in;
                    st_d.flags = flags_in;
                    st_d.sp    = sp_in;
                end else if (iret_req) begin
                    st_d.phase = PH_POP_FL;
                    st_d.sp    = sp_in;
                end
            end
            PH_PUSH_LO: begin
                stk_we     = 1'b1;
                stk_addr   = st_q.sp - SP_W'(1);
                stk_wdata  = st_q.pc[DATA_W-1:0];
                st_d.phase = PH_PUSH_HI;
            end
            PH_PUSH_HI: begin
                stk_we     = 1'b1;
                stk_addr   = st_q.sp - SP_W'(2);
                stk_wdata  = DATA_W'(st_q.pc >> DATA_W);
                st_d.phase = PH_PUSH_FL;
            end
            PH_PUSH_FL: begin
                stk_we     = 1'b1;
                stk_addr   = st_q.sp - SP_W'(3);
                stk_wdata  = st_q.flags;
                sp_wr      = 1'b1;
                sp_new     = st_q.sp - SP_W'(3);
                st_d.phase = PH_IDLE;
            end
            PH_POP_FL: begin
                stk_re     = 1'b1;
                stk_addr   = st_q.sp;
                st_d.flags = stk_rdata;
                st_d.phase = PH_POP_HI;
            end
            PH_POP_HI: begin
                stk_re     = 1'b1;
                stk_addr   = st_q.sp + SP_W'(1);
                st_d.pchi  = stk_rdata;
                st_d.phase = PH_POP_LO;
            end
            PH_POP_LO: begin
                stk_re        = 1'b1;
                stk_addr      = st_q.sp + SP_W'(2);
                restore_valid = 1'b1;
                restore_pc    = ADDR_W'({st_q.pchi, stk_rdata});
                restore_flags = st_q.flags;
                sp_wr         = 1'b1;
                sp_new        = st_q.sp + SP_W'(3);
                st_d.phase    = PH_IDLE;
            end
            default: st_d.phase = PH_IDLE;
        endcase
        if (take)          st_d.halted = 1'b0;
        else if (halt_cmd) st_d.halted = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy   = (st_q.phase != PH_IDLE);
    assign halted = st_q.halted;

    assert_push_after_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (stk_we && stk_addr == SP_W'($past(sp_in) - SP_W'(1))
                  && stk_wdata == $past(pc_in[DATA_W-1:0])));

    assert_pop_after_iret_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !take && iret_req) |=> (stk_re && stk_addr == $past(sp_in)));

    assert_take_only_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !take);

    assert_halt_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !halted);

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
    parameter  int NUM_SRC  = 15,
    parameter  int LO_BITS  = 7,
    parameter  int DATA_W   = 8,
    parameter  int ADDR_W   = 16,
    parameter  int SP_W     = 8,
    parameter  int VEC_BASE = 2,
    localparam int ID_W     = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_pulse,
    input  logic               reg_wr_en,
    input  logic [1:0]         reg_wr_sel,
    input  logic [DATA_W-1:0]  reg_wr_data,
    input  logic [1:0]         reg_rd_sel,
    output logic [DATA_W-1:0]  reg_rd_data,
    input  logic               gie_set,
    input  logic               gie_clr,
    input  logic               cpu_boundary,
    input  logic               halt_cmd,
    input  logic               iret_req,
    input  logic [ADDR_W-1:0]  pc_in,
    input  logic [DATA_W-1:0]  flags_in,
    input  logic [SP_W-1:0]    sp_in,
    output logic               int_ack,
    output logic [ID_W-1:0]    irq_id,
    output logic [ADDR_W-1:0]  vec_addr,
    output logic               halted,
    output logic               stk_we,
    output logic               stk_re,
    output logic [SP_W-1:0]    stk_addr,
    output logic [DATA_W-1:0]  stk_wdata,
    input  logic [DATA_W-1:0]  stk_rdata,
    output logic               sp_wr,
    output logic [SP_W-1:0]    sp_new,
    output logic               restore_valid,
    output logic [ADDR_W-1:0]  restore_pc,
    output logic [DATA_W-1:0]  restore_flags
);

    logic [NUM_SRC-1:0] req, mask, pend_en, win_sel;
    logic               gie, found, busy, take;
    logic [ID_W-1:0]    win_id;

    vic_req_mask #(.NUM_SRC(NUM_SRC), .LO_BITS(LO_BITS), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_pulse (irq_pulse),
        .wr_en     (reg_wr_en),
        .wr_sel    (reg_wr_sel),
        .wr_data   (reg_wr_data),
        .gie_set   (gie_set),
        .gie_clr   (gie_clr),
        .ack       (take),
        .ack_sel   (win_sel),
        .restore   (restore_valid),
        .rd_sel    (reg_rd_sel),
        .rd_data   (reg_rd_data),
        .req_o     (req),
        .mask_o    (mask),
        .gie_o     (gie)
    );

    assign pend_en = req & mask;

    vic_prio_enc #(.N(NUM_SRC)) u_prio (
        .vec   (pend_en),
        .found (found),
        .sel   (win_sel),
        .id    (win_id)
    );

    assign take = !busy && !iret_req && gie && found && (cpu_boundary || halted);

    vic_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SP_W(SP_W)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .take          (take),
        .iret_req      (iret_req),
        .halt_cmd      (halt_cmd),
        .pc_in         (pc_in),
        .flags_in      (flags_in),
        .sp_in         (sp_in),
        .stk_rdata     (stk_rdata),
        .busy          (busy),
        .halted        (halted),
        .stk_we        (stk_we),
        .stk_re        (stk_re),
        .stk_addr      (stk_addr),
        .stk_wdata     (stk_wdata),
        .sp_wr         (sp_wr),
        .sp_new        (sp_new),
        .restore_valid (restore_valid),
        .restore_pc    (restore_pc),
        .restore_flags (restore_flags)
    );

    assign int_ack  = take;
    assign irq_id   = win_id;
    assign vec_addr = ADDR_W'(VEC_BASE) + (ADDR_W'(win_id) << 1);

    assert_winner_lowest_R5: assert property (@(posedge clk) disable iff (!rst_n)
        int_ack |-> ((pend_en & ((NUM_SRC'(1) << irq_id) - NUM_SRC'(1))) == '0));

    assert_taken_is_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        int_ack |-> ((req & mask & (NUM_SRC'(1) << irq_id)) != '0));

    assert_return_reenables_R8: assert property (@(posedge clk) disable iff (!rst_n)
        restore_valid |=> gie);

    assert_no_ack_in_push_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stk_we |-> !int_ack);

endmodule

// File: tb/test_irq_vector_ctrl.sv
`timescale 1ns/1ps
module test_irq_vector_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] irq_pulse = '0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_wr_sel = '0;
    logic [7:0]  reg_wr_data = '0;
    logic [1:0]  reg_rd_sel = '0;
    logic [7:0]  reg_rd_data;
    logic        gie_set = 1'b0, gie_clr = 1'b0, cpu_boundary = 1'b0;
    logic        halt_cmd = 1'b0, iret_req = 1'b0;
    logic [15:0] pc_in = '0;
    logic [7:0]  flags_in = '0, sp_in = '0;
    logic        int_ack, halted, stk_we, stk_re, sp_wr, restore_valid;
    logic [3:0]  irq_id;
    logic [15:0] vec_addr, restore_pc;
    logic [7:0]  stk_addr, stk_wdata, stk_rdata, sp_new, restore_flags;

    logic [7:0] mem [0:255];
    assign stk_rdata = mem[stk_addr];

    always #2.5 clk = ~clk;

    irq_vector_ctrl i_irq_vector_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_pulse(irq_pulse),
        .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
        .reg_rd_sel(reg_rd_sel), .reg_rd_data(reg_rd_data),
        .gie_set(gie_set), .gie_clr(gie_clr), .cpu_boundary(cpu_boundary),
        .halt_cmd(halt_cmd), .iret_req(iret_req),
        .pc_in(pc_in), .flags_in(flags_in), .sp_in(sp_in),
        .int_ack(int_ack), .irq_id(irq_id), .vec_addr(vec_addr), .halted(halted),
        .stk_we(stk_we), .stk_re(stk_re), .stk_addr(stk_addr), .stk_wdata(stk_wdata),
        .stk_rdata(stk_rdata), .sp_wr(sp_wr), .sp_new(sp_new),
        .restore_valid(restore_valid), .restore_pc(restore_pc), .restore_flags(restore_flags)
    );

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    task automatic chk(input string tag, input bit ok, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    logic [14:0] m_req, m_mask;
    logic        m_gie, m_halt;
    int          m_ph;            // 0 idle, 1..3 push, 4..6 pop
    logic [15:0] m_pc;
    logic [7:0]  m_fl, m_sp, m_pchi, m_flr;

    logic        e_take, e_iret, e_we, e_re, e_spwr, e_rv;
    int          e_id;
    logic [7:0]  e_addr, e_wdata, e_spnew, e_rd, e_rfl;
    logic [15:0] e_rpc;

    always @* begin
        logic [14:0] pend;
        pend   = m_req & m_mask;
        e_id   = -1;
        for (int i = 14; i >= 0; i--) if (pend[i]) e_id = i;
        e_take = (m_ph == 0) && !iret_req && m_gie && (e_id >= 0) && (cpu_boundary || m_halt);
        e_iret = (m_ph == 0) && iret_req;
        e_we = 0; e_re = 0; e_spwr = 0; e_rv = 0;
        e_addr = 0; e_wdata = 0; e_spnew = 0; e_rpc = 0; e_rfl = 0;
        case (m_ph)
            1: begin e_we = 1; e_addr = m_sp - 8'd1; e_wdata = m_pc[7:0]; end
            2: begin e_we = 1; e_addr = m_sp - 8'd2; e_wdata = m_pc[15:8]; end
            3: begin e_we = 1; e_addr = m_sp - 8'd3; e_wdata = m_fl;
                     e_spwr = 1; e_spnew = m_sp - 8'd3; end
            4: begin e_re = 1; e_addr = m_sp; end
            5: begin e_re = 1; e_addr = m_sp + 8'd1; end
            6: begin e_re = 1; e_addr = m_sp + 8'd2; e_rv = 1; e_spwr = 1;
                     e_spnew = m_sp + 8'd3; e_rfl = m_flr;
                     e_rpc = {m_pchi, mem[e_addr]}; end
            default: ;
        endcase
        case (reg_rd_sel)
            2'd0: e_rd = {1'b0, m_req[6:0]};
            2'd1: e_rd = m_req[14:7];
            2'd2: e_rd = {m_gie, m_mask[6:0]};
            default: e_rd = m_mask[14:7];
        endcase
    end

    always @(posedge clk) begin
        if (stk_we) mem[stk_addr] <= stk_wdata;
    end

    always @(posedge clk) begin
        logic [14:0] nr, nm;
        logic        ng, nh;
        if (!rst_n) begin
            m_req = '0; m_mask = '0; m_gie = 0; m_halt = 0; m_ph = 0;
            m_pc = 0; m_fl = 0; m_sp = 0; m_pchi = 0; m_flr = 0;
        end else begin
            nr = m_req; nm = m_mask; ng = m_gie; nh = m_halt;
            if (reg_wr_en) begin
                case (reg_wr_sel)
                    2'd0: nr[6:0]  = reg_wr_data[6:0];
                    2'd1: nr[14:7] = reg_wr_data;
                    2'd2: begin nm[6:0] = reg_wr_data[6:0]; ng = reg_wr_data[7]; end
                    default: nm[14:7] = reg_wr_data;
                endcase
            end
            if (gie_set) ng = 1;
            if (gie_clr) ng = 0;
            if (m_ph == 6) ng = 1;
            if (e_take) begin nr[e_id] = 1'b0; ng = 0; end
            nr = nr | irq_pulse;
            if (e_take) nh = 0; else if (halt_cmd) nh = 1;
            case (m_ph)
                0: if (e_take) begin m_ph = 1; m_pc = pc_in; m_fl = flags_in; m_sp = sp_in; end
                   else if (e_iret) begin m_ph = 4; m_sp = sp_in; end
                4: begin m_flr = mem[m_sp]; m_ph = 5; end
                5: begin m_pchi = mem[m_sp + 8'd1]; m_ph = 6; end
                3, 6: m_ph = 0;
                default: m_ph = m_ph + 1;
            endcase
            m_req = nr; m_mask = nm; m_gie = ng; m_halt = nh;
        end
    end

    task automatic cmp();
        chk("R5 acknowledge", int_ack === e_take, int_ack, e_take);
        if (e_take) begin
            chk("R5 source number", irq_id === 4'(e_id), irq_id, e_id);
            chk("R5 vector address", vec_addr === 16'(2 * e_id + 2), vec_addr, 2 * e_id + 2);
        end
        chk("R7 stack strobes", {stk_we, stk_re, sp_wr} === {e_we, e_re, e_spwr},
            {stk_we, stk_re, sp_wr}, {e_we, e_re, e_spwr});
        if (e_we || e_re) chk("R7 stack address", stk_addr === e_addr, stk_addr, e_addr);
        if (e_we) chk("R7 stack data", stk_wdata === e_wdata, stk_wdata, e_wdata);
        if (e_spwr) chk("R8 new stack pointer", sp_new === e_spnew, sp_new, e_spnew);
        chk("R8 restore strobe", restore_valid === e_rv, restore_valid, e_rv);
        if (e_rv) begin
            chk("R8 restore address", restore_pc === e_rpc, restore_pc, e_rpc);
            chk("R8 restore flags", restore_flags === e_rfl, restore_flags, e_rfl);
        end
        chk("R9 halted", halted === m_halt, halted, m_halt);
        chk("R1 register read", reg_rd_data === e_rd, reg_rd_data, e_rd);
    endtask

    task automatic step();
        #1;
        if (rst_n) cmp();
        @(negedge clk);
        irq_pulse = '0; reg_wr_en = 0; gie_set = 0; gie_clr = 0;
        halt_cmd = 0; iret_req = 0;
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        reg_wr_en = 1; reg_wr_sel = s; reg_wr_data = d;
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] s, input logic [7:0] exp);
        reg_rd_sel = s;
        #1 chk(tag, reg_rd_data === exp, reg_rd_data, exp);
        step();
    endtask

    task automatic run_iret(input logic [7:0] sp);
        iret_req = 1; sp_in = sp; step();
        repeat (3) step();
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        @(negedge clk); @(negedge clk); @(negedge clk);
        rst_n = 1;
        // R1 reset state
        for (int s = 0; s < 4; s++) rd_chk("R1 reset value", 2'(s), 8'h00);
        #1 chk("R1 idle after reset", {int_ack, stk_we, stk_re} === 3'b000, {int_ack, stk_we, stk_re}, 0);
        wr(2'd2, 8'h85); step();
        wr(2'd3, 8'h01); step();
        rd_chk("R1 low enable readback", 2'd2, 8'h85);
        rd_chk("R1 high enable readback", 2'd3, 8'h01);
        // R4 global enable commands
        gie_clr = 1; step();
        rd_chk("R4 disable keeps enables", 2'd2, 8'h05);
        gie_set = 1; step();
        rd_chk("R4 enable sets top bit", 2'd2, 8'h85);
        // R6 masked source stays pending, never taken
        cpu_boundary = 1;
        irq_pulse = 15'h0020; step();
        for (int k = 0; k < 4; k++) begin
            #1 chk("R6 masked not taken", int_ack === 1'b0, int_ack, 0);
            step();
        end
        rd_chk("R6 masked stays readable", 2'd0, 8'h20);
        // R3 software-set request on IRQ7
        pc_in = 16'h1234; flags_in = 8'h5A; sp_in = 8'h80;
        wr(2'd1, 8'h01); step();
        #1 chk("R3 software request taken", {int_ack, irq_id, vec_addr} === {1'b1, 4'd7, 16'd16},
               {int_ack, irq_id, vec_addr}, {1'b1, 4'd7, 16'd16});
        step();
        #1 chk("R7 first push", {stk_addr, stk_wdata} === 16'h7F34, {stk_addr, stk_wdata}, 16'h7F34);
        step();
        #1 chk("R7 second push", {stk_addr, stk_wdata} === 16'h7E12, {stk_addr, stk_wdata}, 16'h7E12);
        step();
        #1 chk("R7 flags push", {stk_addr, stk_wdata, sp_new} === 24'h7D5A7D,
               {stk_addr, stk_wdata, sp_new}, 24'h7D5A7D);
        step();
        rd_chk("R5 enable cleared on entry", 2'd2, 8'h05);
        rd_chk("R5 serviced bit cleared", 2'd1, 8'h00);
        // R2 pulse beats software clear
        wr(2'd0, 8'h00); irq_pulse = 15'h0002; step();
        rd_chk("R2 pulse wins over clear", 2'd0, 8'h02);
        // R8 return
        iret_req = 1; sp_in = 8'h7D; step();
        step(); step();
        #1 chk("R8 restore values", {restore_valid, restore_pc, restore_flags, sp_new} === {1'b1, 16'h1234, 8'h5A, 8'h80},
               {restore_valid, restore_pc, restore_flags, sp_new}, {1'b1, 16'h1234, 8'h5A, 8'h80});
        step();
        rd_chk("R8 enable restored", 2'd2, 8'h85);
        // R5 priority order: IRQ0 then IRQ2 then IRQ7
        cpu_boundary = 0;
        irq_pulse = 15'h0005; wr(2'd1, 8'h01); step();
        cpu_boundary = 1;
        #1 chk("R5 lowest first", {int_ack, vec_addr} === {1'b1, 16'd2}, {int_ack, vec_addr}, {1'b1, 16'd2});
        step(); repeat (3) step();
        run_iret(8'h40);
        #1 chk("R5 second priority", {int_ack, vec_addr} === {1'b1, 16'd6}, {int_ack, vec_addr}, {1'b1, 16'd6});
        step(); repeat (3) step();
        run_iret(8'h40);
        #1 chk("R5 third priority", {int_ack, vec_addr} === {1'b1, 16'd16}, {int_ack, vec_addr}, {1'b1, 16'd16});
        step(); repeat (3) step();
        run_iret(8'h40);
        // R10 return beats acknowledge; no acknowledge during push
        cpu_boundary = 0; irq_pulse = 15'h0001; step();
        cpu_boundary = 1; iret_req = 1; sp_in = 8'h40;
        #1 chk("R10 return wins", int_ack === 1'b0, int_ack, 0);
        step();
        #1 chk("R10 pop started", stk_re === 1'b1, stk_re, 1);
        step(); step(); step();
        #1 chk("R10 taken after return", int_ack === 1'b1, int_ack, 1);
        step();
        for (int k = 0; k < 3; k++) begin
            irq_pulse = 15'h0004;
            #1 chk("R10 no ack during push", int_ack === 1'b0, int_ack, 0);
            step();
        end
        // R9 halt exit
        cpu_boundary = 0;
        halt_cmd = 1; step();
        #1 chk("R9 halted set", halted === 1'b1, halted, 1);
        step();
        gie_set = 1; step();
        #1 chk("R9 taken while halted", int_ack === 1'b1, int_ack, 1);
        step();
        #1 chk("R9 halt cleared", halted === 1'b0, halted, 0);
        step(); step(); step();
        // pseudo-random traffic checked against the model every cycle
        begin
            logic [31:0] x, y;
            x = 32'h1F2E3D4C;
            for (int n = 0; n < 3000; n++) begin
                x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
                y = x ^ (x << 13); y = y ^ (y >> 17); y = y ^ (y << 5);
                irq_pulse    = (x[3:0] == 4'd0) ? 15'(16'd1 << x[7:4]) : '0;
                reg_wr_en    = (x[10:8] == 3'd0);
                reg_wr_sel   = x[12:11];
                reg_wr_data  = x[20:13];
                gie_set      = (x[23:21] == 3'd0);
                gie_clr      = (x[26:24] == 3'd0) && y[0];
                cpu_boundary = x[27];
                iret_req     = (x[31:28] == 4'd0);
                halt_cmd     = (y[4:1] == 4'd0);
                pc_in        = y[20:5];
                flags_in     = y[28:21];
                sp_in        = {y[31:29], y[4:0]};
                reg_rd_sel   = y[10:9];
                step();
            end
        end
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule